// File: doc/BRIEF.md
# Phase-Accumulator Tick Generator

This block makes a stream of single-cycle ticks whose average rate is a fraction of the input clock: f_clk × inc / 2^ACC_W. On each enabled clock it adds a programmable increment to an ACC_W-bit phase register. The overflow of that sum is kept in an extra carry bit, which is the tick output. Ticks are not evenly spaced. Their spacing alternates between the floor and the ceiling of 2^ACC_W / inc, so the average rate is exact over a full window. The block is meant to pace serial bit timing or sample strobes from a fast system clock, with no divisor counter and no terminal-count compare.

A second output, `flip`, pulses for one cycle whenever the top bit of the phase register changes. It gives twice as many events as the tick for increments below half the modulus, which is useful when both edges of a derived waveform matter.

Top module: `phase_tick_gen`

## Requirements
- R1: `rst` is synchronous and active high. It clears the phase, the carry bit and the stored phase MSB, so `tick` and `flip` are low in the cycle after a reset edge. After reset, with `inc`=1 held and `en` high, the first tick follows exactly 2^ACC_W enabled edges.
- R2: On every edge where `en` is high, the phase becomes (phase + `inc`) mod 2^ACC_W. `tick` is high in the following cycle if and only if phase + `inc` ≥ 2^ACC_W.
- R3: Over any 2^ACC_W consecutive enabled edges with a fixed `inc`, exactly `inc` ticks occur, for every `inc` from 0 to 2^ACC_W−1.
- R4: `flip` is high in a cycle if and only if bit ACC_W−1 of the phase changed at the preceding edge.
- R5: For 0 < `inc` < 2^(ACC_W−1), `flip` pulses 2×`inc` times per 2^ACC_W enabled edges. With ACC_W=4 and `inc`=3, that is 6 pulses per 16 cycles, an average division of 8/3.
- R6: On an edge where `en` is low, the phase is held and the carry bit is cleared. In the following cycle `tick` and `flip` are both low. Accumulation then resumes from the held phase.
- R7: At the default width (ACC_W=10) with `inc`=59, exactly 59 ticks occur in 1024 enabled cycles, an average ratio of 1024/59.
- R8: A new `inc` value applies from the first edge at which it is sampled. No earlier edge is affected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk  | input  | 1 | Clock |
| rst  | input  | 1 | Synchronous active-high reset |
| en   | input  | 1 | Advance the phase on this edge |
| inc  | input  | ACC_W | Phase increment per enabled edge |
| tick | output | 1 | Carry out of the last phase addition |
| flip | output | 1 | Pulse on any change of the phase MSB |

## Verification
The assertions assume that `inc` is never 2^ACC_W or above, which its port width guarantees. They also compare each carry against the increment sampled one edge earlier, so they take `inc` to be a synchronous input, settled before each edge. The bench changes `inc` and `en` only at falling edges. It sweeps every increment of a 4-bit instance from a known reset phase, and mixes enabled and disabled cycles with changing increments, so every sampled value is defined and legal.

// File: rtl/phase_tick_pkg.sv
package phase_tick_pkg;

    // Default phase width: gives a 1024-cycle averaging window.
    localparam int DEFAULT_ACC_W = 10;

    // The two event outputs carried as one bundle.
    typedef struct packed {
        logic carry_tick;   // overflow of the phase addition
        logic msb_flip;     // change of the phase top bit
    } tick_pair_t;

    // Number of MSB changes expected per full window for a small increment.
    function automatic int flips_per_window(input int incr);
        return 2 * incr;
    endfunction

endpackage

// File: rtl/phase_accum.sv
module phase_accum #(
    parameter int ACC_W = phase_tick_pkg::DEFAULT_ACC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [ACC_W-1:0] inc,
    output logic             carry_o,
    output logic [ACC_W-1:0] phase_o
);
    localparam int SUM_W = ACC_W + 1;

    logic [SUM_W-1:0] acc_q;
    logic [SUM_W-1:0] acc_d;
    logic [SUM_W-1:0] base;

    // The previous carry is always dropped, so only the phase feeds the sum.
    assign base = {1'b0, acc_q[ACC_W-1:0]};

    always_comb begin
        if (en) begin
            acc_d = base + {1'b0, inc};
        end else begin
            acc_d = base;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign carry_o = acc_q[ACC_W];
    assign phase_o = acc_q[ACC_W-1:0];

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (phase_o == '0) && !carry_o);

    // R6
    hold_phase_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(phase_o));

    // R6
    idle_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !carry_o);

    // R2
    carry_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !$isunknown(inc)) |=> (!carry_o || (phase_o < $past(inc))));

endmodule

// File: rtl/msb_transition.sv
module msb_transition (
    input  logic clk,
    input  logic rst,
    input  logic msb_i,
    output logic flip_o
);
    logic msb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            msb_q <= 1'b0;
        end else begin
            msb_q <= msb_i;
        end
    end

    assign flip_o = msb_i ^ msb_q;

endmodule

// File: rtl/phase_tick_gen.sv
module phase_tick_gen #(
    parameter int ACC_W = phase_tick_pkg::DEFAULT_ACC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [ACC_W-1:0] inc,
    output logic             tick,
    output logic             flip
);
    import phase_tick_pkg::*;

    localparam int MSB = ACC_W - 1;

    logic [ACC_W-1:0] phase;
    logic             carry;
    tick_pair_t       events;

    phase_accum #(.ACC_W(ACC_W)) u_accum (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .inc     (inc),
        .carry_o (carry),
        .phase_o (phase)
    );

    msb_transition u_msb (
        .clk    (clk),
        .rst    (rst),
        .msb_i  (phase[MSB]),
        .flip_o (events.msb_flip)
    );

    assign events.carry_tick = carry;
    assign tick = events.carry_tick;
    assign flip = events.msb_flip;

    // R4
    flip_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        flip |-> $past(en));

    // R6
    tick_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        tick |-> $past(en));

endmodule

// File: tb/phase_tick_gen_bench.sv
`timescale 1ns/1ps
module phase_tick_gen_bench;
    localparam int NW = 4;
    localparam int NMOD = 1 << NW;
    localparam int WW = 10;
    localparam int WMOD = 1 << WW;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst = 1'b1;
    logic          en = 1'b0;
    logic [NW-1:0] inc = '0;
    logic          tick, flip;

    logic          w_rst = 1'b1;
    logic          w_en = 1'b0;
    logic [WW-1:0] w_inc = '0;
    logic          w_tick, w_flip;

    phase_tick_gen #(.ACC_W(NW)) u_phase_tick_gen (
        .clk(clk), .rst(rst), .en(en), .inc(inc), .tick(tick), .flip(flip));

    phase_tick_gen #(.ACC_W(WW)) u_phase_tick_gen_wide (
        .clk(clk), .rst(w_rst), .en(w_en), .inc(w_inc), .tick(w_tick), .flip(w_flip));

    int tests = 0;
    int fails = 0;
    int m_phase = 0;
    int seq_bad = 0;
    int n_ticks = 0;
    int n_flips = 0;

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock of the narrow instance, compared against the arithmetic model.
    task automatic step(input bit e, input int incv);
        int old;
        int s;
        bit et;
        bit ef;
        en  = e;
        inc = incv[NW-1:0];
        @(posedge clk);
        old = m_phase;
        if (e) begin
            s = old + incv;
            et = (s >= NMOD);
            m_phase = s % NMOD;
        end else begin
            et = 1'b0;
        end
        ef = (((m_phase >> (NW-1)) & 1) != ((old >> (NW-1)) & 1));
        @(negedge clk);
        if (tick !== et || flip !== ef) begin
            if (seq_bad == 0)
                $display("FAIL R2/R4/R8 cycle model: tick=%0b/%0b flip=%0b/%0b (actual/expected)",
                         tick, et, flip, ef);
            seq_bad++;
        end
        if (tick === 1'b1) n_ticks++;
        if (flip === 1'b1) n_flips++;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        en  = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_phase = 0;
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: outputs low straight after reset
        check("R1 tick after reset", int'(tick), 0);
        check("R1 flip after reset", int'(flip), 0);

        // R2, R3, R5: every increment over one full window from phase 0
        for (int k = 0; k < NMOD; k++) begin
            do_reset();
            seq_bad = 0; n_ticks = 0; n_flips = 0;
            for (int c = 0; c < NMOD; c++) step(1'b1, k);
            check("R2 per-cycle sequence", seq_bad, 0);
            check("R3 ticks per window", n_ticks, k);
            if (k > 0 && k < NMOD / 2)
                check("R5 flips per window", n_flips, phase_tick_pkg::flips_per_window(k));
        end

        // R3: window starting from a non-zero phase
        do_reset();
        for (int c = 0; c < 5; c++) step(1'b1, 7);
        n_ticks = 0;
        for (int c = 0; c < NMOD; c++) step(1'b1, 7);
        check("R3 offset window", n_ticks, 7);

        // R1: mid-run reset, then inc=1 gives its first tick on edge 2^W
        rst = 1'b1;
        en  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 mid-run reset tick", int'(tick), 0);
        check("R1 mid-run reset flip", int'(flip), 0);
        rst = 1'b0;
        m_phase = 0;
        n_ticks = 0;
        for (int c = 0; c < NMOD - 1; c++) step(1'b1, 1);
        check("R1 no tick before 2^W edges", n_ticks, 0);
        step(1'b1, 1);
        check("R1 tick on edge 2^W", int'(tick), 1);

        // R6, R8: enable gaps and increment changes, model-compared
        do_reset();
        seq_bad = 0;
        for (int c = 0; c < 60; c++) step((c % 5) != 2, 3 + (c / 7) % 9);
        check("R6/R8 gated mixed sequence", seq_bad, 0);

        // R6: phase held across a long gap, then resumes
        do_reset();
        for (int c = 0; c < 3; c++) step(1'b1, 5);   // phase 15, no carry yet
        step(1'b0, 5);
        check("R6 tick low while idle", int'(tick), 0);
        check("R6 flip low while idle", int'(flip), 0);
        for (int c = 0; c < 6; c++) step(1'b0, 9);
        check("R6 still idle", int'(tick) + int'(flip), 0);
        step(1'b1, 1);                                // 15+1 wraps only if phase was held
        check("R6 resume from held phase", int'(tick), 1);

        // R7: default width, increment 59
        rst = 1'b1;
        w_inc = 10'd59;
        w_en = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        w_rst = 1'b0;
        n_ticks = 0; n_flips = 0;
        for (int c = 0; c < WMOD; c++) begin
            @(negedge clk);
            if (w_tick === 1'b1) n_ticks++;
            if (w_flip === 1'b1) n_flips++;
        end
        check("R7 ticks per 1024 cycles", n_ticks, 59);
        check("R5 wide flips per window", n_flips, 118);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule